// File: doc/BRIEF.md
# Folded Cascaded Third-Order IIR Filter

This block realises an IIR filter whose order can be chosen at run time as any multiple of three from 3 to 24. Only one third-order section exists in hardware. For every accepted input sample, that section is stepped through 1 to 8 cascaded stages in turn. Stage k's output is the input to stage k+1 for the same sample. Each stage keeps its own coefficient set and its own three delay registers. A stage's work is complete before the next stage starts.

The filter holds one sample at a time. An upstream producer waits for `inReady`, presents a sample with `inValid`, and receives the filtered value on `outData` with a one-cycle `outValid` strobe. Software or a configuration engine loads coefficients through a simple write port. A select input sets the number of active stages. Any change of that select wipes every stage's delay state before the next sample is processed.

Top module: `cascade_fold_iir`

## Requirements
- R1: After reset, `outValid` is 0, `outData` is 0, every coefficient and delay value is 0, the active stage count is 1 (`stageSel` = 0), and `inReady` is 1 while `stageSel` stays 0.
- R2: Each stage computes y = sat(round(b0·x + d1)) and then updates d1 ← b1·x − a1·y + d2, d2 ← b2·x − a2·y + d3, d3 ← b3·x − a3·y. Samples and coefficients are signed Q1.15, products and delays are 40-bit signed with wrap-around, and the feedback terms use the rounded 16-bit y.
- R3: The number of active stages is `stageSel`+1 (order 3·(`stageSel`+1)). Stage 0 receives the input sample, stage k+1 receives stage k's rounded output, and the last active stage's output is what `outData` presents.
- R4: If a sample is accepted on clock edge E with N active stages, `outValid` is high for exactly one cycle, starting right after edge E+2N.
- R5: `inReady` is low from the cycle after acceptance until the cycle in which `outValid` is high. A new sample may be accepted in that `outValid` cycle.
- R6: Rounding to the output adds 2^14 to the 40-bit accumulator and shifts it arithmetically right by 15. The result is saturated to the range [−32768, 32767].
- R7: Each stage's delay registers keep their values from one sample to the next and are updated only while that stage is being processed.
- R8: Whenever `stageSel` differs from the count in use, `inReady` drops. The block then clears all delay registers of all stages before it accepts another sample. This also applies when the select is changed and then changed back.
- R9: With `cfgWe` high on a clock edge, `cfgData` is written into stage `cfgStage`. The coefficient is chosen by `cfgIdx`, encoded 0=b0, 1=b1, 2=b2, 3=b3, 4=a1, 5=a2, 6=a3. A write with `cfgIdx` = 7 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input sample present |
| inData | input | 16 | Input sample, signed Q1.15 |
| inReady | output | 1 | Block can take a sample this cycle |
| outValid | output | 1 | One-cycle strobe marking a filtered sample |
| outData | output | 16 | Filtered sample, signed Q1.15 |
| stageSel | input | 3 | Active stage count minus one |
| cfgWe | input | 1 | Coefficient write enable |
| cfgStage | input | 3 | Stage whose coefficient is written |
| cfgIdx | input | 3 | Coefficient index within the stage |
| cfgData | input | 16 | Coefficient value, signed Q1.15 |

## Verification
The assertions check the handshake timing on every cycle. They confirm that each result arrives exactly 2N edges after acceptance, that the output strobe lasts a single cycle, that `inReady` stays low while a sample is in flight, and that a select change blocks acceptance at once. Only the bench's scenarios can show that the filtered values are right. Those scenarios cover the cascade of stage outputs, per-stage state persistence, rounding and saturation at both rails, clearing after a select change that is reverted, and an ignored coefficient write. The bench compares against an arithmetic model on every clock.

// File: rtl/cfi_pkg.sv
package cfi_pkg;
  localparam int DATA_W     = 16;
  localparam int ACC_W      = 40;
  localparam int FRAC_W     = 15;
  localparam int MAX_STAGES = 8;
  localparam int NUM_COEF   = 7;
  localparam int STG_W      = $clog2(MAX_STAGES);
  localparam int IDX_W      = $clog2(NUM_COEF + 1);

  typedef logic signed [DATA_W-1:0] sample_t;
  typedef logic signed [ACC_W-1:0]  acc_t;

  // coefficient index encoding seen on the write port
  typedef enum logic [IDX_W-1:0] {
    CO_B0 = 3'd0, CO_B1 = 3'd1, CO_B2 = 3'd2, CO_B3 = 3'd3,
    CO_A1 = 3'd4, CO_A2 = 3'd5, CO_A3 = 3'd6
  } coefIdx_e;

  typedef struct packed {
    sample_t b0;
    sample_t b1;
    sample_t b2;
    sample_t b3;
    sample_t a1;
    sample_t a2;
    sample_t a3;
  } coefSet_t;

  typedef struct packed {
    acc_t d1;
    acc_t d2;
    acc_t d3;
  } delaySet_t;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic             loadIn;
    logic             evalOut;
    logic             updState;
    logic             passOn;
    logic             emit;
    logic             clearAll;
    logic [STG_W-1:0] stage;
  } strobe_t;

  // full-precision Q2.30 product, sign-extended to accumulator width
  function automatic acc_t mulExt(input sample_t a, input sample_t b);
    logic signed [2*DATA_W-1:0] prod;
    prod = a * b;
    return acc_t'(prod);
  endfunction

  // round half up at bit FRAC_W-1, then clamp to the sample range
  function automatic sample_t roundSat(input acc_t acc);
    acc_t half;
    acc_t hiLim;
    acc_t loLim;
    acc_t shifted;
    half             = '0;
    half[FRAC_W-1]   = 1'b1;
    hiLim            = '0;
    hiLim[DATA_W-2:0] = '1;
    loLim            = ~hiLim;
    shifted          = (acc + half) >>> FRAC_W;
    if (shifted > hiLim) return sample_t'(hiLim);
    if (shifted < loLim) return sample_t'(loLim);
    return sample_t'(shifted);
  endfunction
endpackage

// File: rtl/cfi_ctrl.sv
module cfi_ctrl
  import cfi_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [STG_W-1:0] stageSel,
  output logic             inReady,
  output strobe_t          strobe
);
  typedef enum logic [1:0] {ST_IDLE, ST_CLEAR, ST_EVAL, ST_UPD} phase_e;

  phase_e           phase;
  phase_e           phaseNxt;
  logic [STG_W-1:0] curSel;
  logic [STG_W-1:0] stageCnt;
  logic             selDirty;
  logic             selMatch;
  logic             lastStage;
  logic             accept;

  always_comb begin
    selMatch  = (stageSel == curSel);
    inReady   = (phase == ST_IDLE) && selMatch && !selDirty;
    accept    = inValid && inReady;
    lastStage = (stageCnt == curSel);

    strobe.loadIn   = accept;
    strobe.evalOut  = (phase == ST_EVAL);
    strobe.updState = (phase == ST_UPD);
    strobe.passOn   = (phase == ST_UPD) && !lastStage;
    strobe.emit     = (phase == ST_UPD) && lastStage;
    strobe.clearAll = (phase == ST_CLEAR);
    strobe.stage    = stageCnt;

    phaseNxt = phase;
    case (phase)
      ST_IDLE: begin
        if (!selMatch || selDirty) phaseNxt = ST_CLEAR;
        else if (accept)           phaseNxt = ST_EVAL;
      end
      ST_CLEAR: phaseNxt = ST_IDLE;
      ST_EVAL:  phaseNxt = ST_UPD;
      ST_UPD:   phaseNxt = lastStage ? ST_IDLE : ST_EVAL;
      default:  phaseNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= ST_IDLE;
      curSel   <= '0;
      stageCnt <= '0;
      selDirty <= 1'b0;
    end else begin
      phase <= phaseNxt;
      // any select mismatch seen outside a clear cycle forces a clear later
      if (phase == ST_CLEAR) begin
        curSel   <= stageSel;
        selDirty <= 1'b0;
      end else if (!selMatch) begin
        selDirty <= 1'b1;
      end
      if (accept)
        stageCnt <= '0;
      else if (phase == ST_UPD && !lastStage)
        stageCnt <= stageCnt + 1'b1;
    end
  end
endmodule

// File: rtl/cfi_datapath.sv
module cfi_datapath
  import cfi_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobe,
  input  sample_t          inData,
  input  logic             cfgWe,
  input  logic [STG_W-1:0] cfgStage,
  input  logic [IDX_W-1:0] cfgIdx,
  input  sample_t          cfgData,
  output logic             outValid,
  output sample_t          outData
);
  coefSet_t  coefBank  [MAX_STAGES];
  delaySet_t delayBank [MAX_STAGES];

  sample_t   xReg;
  sample_t   yReg;
  coefSet_t  cSel;
  delaySet_t dSel;
  delaySet_t dNext;
  acc_t      yAcc;

  for (genvar g = 0; g < MAX_STAGES; g++) begin : gStage
    coefSet_t  cReg;
    delaySet_t dReg;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cReg <= '0;
      end else if (cfgWe && cfgStage == STG_W'(g)) begin
        case (cfgIdx)
          CO_B0:   cReg.b0 <= cfgData;
          CO_B1:   cReg.b1 <= cfgData;
          CO_B2:   cReg.b2 <= cfgData;
          CO_B3:   cReg.b3 <= cfgData;
          CO_A1:   cReg.a1 <= cfgData;
          CO_A2:   cReg.a2 <= cfgData;
          CO_A3:   cReg.a3 <= cfgData;
          default: cReg <= cReg;
        endcase
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        dReg <= '0;
      else if (strobe.clearAll)
        dReg <= '0;
      else if (strobe.updState && strobe.stage == STG_W'(g))
        dReg <= dNext;
    end

    assign coefBank[g]  = cReg;
    assign delayBank[g] = dReg;
  end

  // shared third-order section, transposed structure
  always_comb begin
    cSel     = coefBank[strobe.stage];
    dSel     = delayBank[strobe.stage];
    yAcc     = mulExt(cSel.b0, xReg) + dSel.d1;
    dNext.d1 = mulExt(cSel.b1, xReg) - mulExt(cSel.a1, yReg) + dSel.d2;
    dNext.d2 = mulExt(cSel.b2, xReg) - mulExt(cSel.a2, yReg) + dSel.d3;
    dNext.d3 = mulExt(cSel.b3, xReg) - mulExt(cSel.a3, yReg);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xReg     <= '0;
      yReg     <= '0;
      outData  <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= strobe.emit;
      if (strobe.loadIn)      xReg <= inData;
      else if (strobe.passOn) xReg <= yReg;
      if (strobe.evalOut)     yReg <= roundSat(yAcc);
      if (strobe.emit)        outData <= yReg;
    end
  end
endmodule

// File: rtl/cascade_fold_iir.sv
module cascade_fold_iir
  import cfi_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic signed [DATA_W-1:0] inData,
  output logic                     inReady,
  output logic                     outValid,
  output logic signed [DATA_W-1:0] outData,
  input  logic [STG_W-1:0]         stageSel,
  input  logic                     cfgWe,
  input  logic [STG_W-1:0]         cfgStage,
  input  logic [IDX_W-1:0]         cfgIdx,
  input  logic signed [DATA_W-1:0] cfgData
);
  strobe_t strobe;

  cfi_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .stageSel (stageSel),
    .inReady  (inReady),
    .strobe   (strobe)
  );

  cfi_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .inData   (inData),
    .cfgWe    (cfgWe),
    .cfgStage (cfgStage),
    .cfgIdx   (cfgIdx),
    .cfgData  (cfgData),
    .outValid (outValid),
    .outData  (outData)
  );
endmodule

// File: rtl/cfi_checker.sv
module cfi_checker
  import cfi_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             inReady,
  input logic             outValid,
  input logic [STG_W-1:0] stageSel
);
  localparam int CNT_W = $clog2(2 * MAX_STAGES + 2) + 1;

  logic             armed;
  logic             pend;
  logic [CNT_W-1:0] cnt;
  logic [STG_W:0]   nStg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed <= 1'b0;
      pend  <= 1'b0;
      cnt   <= '0;
      nStg  <= '0;
    end else begin
      armed <= 1'b1;
      if (inValid && inReady) begin
        pend <= 1'b1;
        cnt  <= CNT_W'(1);
        nStg <= (STG_W+1)'(stageSel) + 1'b1;
      end else if (pend) begin
        if (outValid) pend <= 1'b0;
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (pend && int'(cnt) == 2 * int'(nStg) + 1)); // R4

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid); // R4

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    (pend && !outValid) |-> !inReady); // R5

  AST_SEL_CHANGE_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (armed && stageSel != $past(stageSel)) |-> !inReady); // R8
endmodule

bind cascade_fold_iir cfi_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inReady  (inReady),
  .outValid (outValid),
  .stageSel (stageSel)
);

// File: tb/cascade_fold_iir_test.sv
module cascade_fold_iir_test;
  logic               clk = 1'b0;
  logic               rstN;
  logic               inValid;
  logic signed [15:0] inData;
  logic               inReady;
  logic               outValid;
  logic signed [15:0] outData;
  logic [2:0]         stageSel;
  logic               cfgWe;
  logic [2:0]         cfgStage;
  logic [2:0]         cfgIdx;
  logic signed [15:0] cfgData;

  int     nTests = 0;
  int     nFail  = 0;
  int     cyc    = 0;
  bit     started = 0;
  bit     done    = 0;
  longint lastOut = 0;
  bit     modelDirty = 0;
  longint mc [8][7];
  longint ms [8][3];
  int     dueQ[$];
  longint valQ[$];

  always #2.5 clk = ~clk;

  cascade_fold_iir uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .inReady(inReady), .outValid(outValid), .outData(outData),
    .stageSel(stageSel), .cfgWe(cfgWe), .cfgStage(cfgStage),
    .cfgIdx(cfgIdx), .cfgData(cfgData)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic longint w40(input longint v);
    return (v <<< 24) >>> 24;
  endfunction

  function automatic longint rs(input longint acc);
    longint r;
    r = (acc + 16384) >>> 15;
    if (r > 32767)  return 32767;
    if (r < -32768) return -32768;
    return r;
  endfunction

  function automatic longint modelRun(input longint xin, input int n);
    longint x;
    longint y;
    longint d1;
    longint d2;
    longint d3;
    x = xin;
    for (int k = 0; k < n; k++) begin
      y  = rs(w40(mc[k][0] * x + ms[k][0]));
      d1 = w40(mc[k][1] * x - mc[k][4] * y + ms[k][1]);
      d2 = w40(mc[k][2] * x - mc[k][5] * y + ms[k][2]);
      d3 = w40(mc[k][3] * x - mc[k][6] * y);
      ms[k][0] = d1; ms[k][1] = d2; ms[k][2] = d3;
      x = y;
    end
    return x;
  endfunction

  // monitor: sampled mid-cycle, compares against the model every clock
  always @(negedge clk) begin
    if (rstN && started && !done) begin
      bit expV;
      cyc++;
      expV = (dueQ.size() > 0) && (dueQ[0] == cyc);
      check("R4 outValid timing", longint'(outValid), longint'(expV));
      if (outValid) lastOut = longint'(outData);
      if (expV) begin
        check("R2 R3 outData value", longint'(outData), valQ[0]);
        void'(dueQ.pop_front());
        void'(valQ.pop_front());
      end else if (dueQ.size() > 0) begin
        check("R5 inReady low while busy", longint'(inReady), 0);
      end
      if (inValid && inReady) begin
        int n;
        n = int'(stageSel) + 1;
        if (modelDirty) begin
          for (int k = 0; k < 8; k++)
            for (int j = 0; j < 3; j++) ms[k][j] = 0;
          modelDirty = 0;
        end
        dueQ.push_back(cyc + 2 * n + 1);
        valQ.push_back(modelRun(longint'(inData), n));
      end
    end
  end

  task automatic cfgWrite(input int s, input int i, input int d);
    @(posedge clk); #1;
    cfgWe = 1'b1; cfgStage = 3'(s); cfgIdx = 3'(i); cfgData = 16'(d);
    if (i < 7) mc[s][i] = longint'(d);
    @(posedge clk); #1;
    cfgWe = 1'b0;
  endtask

  task automatic setSel(input int v);
    @(posedge clk); #1;
    if (3'(v) != stageSel) modelDirty = 1;
    stageSel = 3'(v);
  endtask

  task automatic sendWait(input int x);
    @(posedge clk); #1;
    inValid = 1'b1; inData = 16'(x);
    do @(negedge clk); while (!inReady);
    @(posedge clk); #1;
    inValid = 1'b0;
    while (dueQ.size() > 0) @(negedge clk);
  endtask

  task automatic clearStage0(input int b0, input int b1);
    for (int i = 0; i < 7; i++) cfgWrite(0, i, 0);
    cfgWrite(0, 0, b0);
    cfgWrite(0, 1, b1);
    setSel(1);
    setSel(0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nTests++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    for (int k = 0; k < 8; k++) begin
      for (int j = 0; j < 7; j++) mc[k][j] = 0;
      for (int j = 0; j < 3; j++) ms[k][j] = 0;
    end
    rstN = 1'b0; inValid = 1'b0; inData = '0; stageSel = '0;
    cfgWe = 1'b0; cfgStage = '0; cfgIdx = '0; cfgData = '0;
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    started = 1;
    @(negedge clk);
    check("R1 outValid after reset", longint'(outValid), 0);
    check("R1 outData after reset", longint'(outData), 0);
    check("R1 inReady after reset", longint'(inReady), 1);
    sendWait(12345);
    check("R1 zero coefficients give zero", lastOut, 0);

    // R2: plain gain
    cfgWrite(0, 0, 16'h4000);
    sendWait(16'h2000);
    check("R2 half gain", lastOut, 4096);

    // R6: rounding
    sendWait(1);
    check("R6 round 0.5 up", lastOut, 1);
    sendWait(-1);
    check("R6 round -0.5 up", lastOut, 0);
    sendWait(3);
    check("R6 round 1.5 up", lastOut, 2);

    // R6: saturation at both rails
    clearStage0(32767, 32767);
    sendWait(32767);
    check("R6 near full scale", lastOut, 32766);
    sendWait(32767);
    check("R6 positive saturation", lastOut, 32767);
    clearStage0(32767, 32767);
    sendWait(-32768);
    sendWait(-32768);
    check("R6 negative saturation", lastOut, -32768);

    // R7 persistence and R8 clearing after a reverted select change
    clearStage0(16'h4000, 16'h4000);
    sendWait(16'h2000);
    sendWait(0);
    check("R7 stage state kept", lastOut, 4096);
    setSel(1);
    @(negedge clk);
    check("R8 inReady drops on select change", longint'(inReady), 0);
    setSel(0);
    sendWait(0);
    check("R8 state cleared after reverted change", lastOut, 0);

    // R9: index 7 ignored
    clearStage0(16'h4000, 0);
    cfgWrite(0, 7, 32767);
    sendWait(16'h2000);
    check("R9 index 7 write ignored", lastOut, 4096);

    // R3: two-stage cascade
    cfgWrite(1, 0, 16'h4000);
    setSel(1);
    sendWait(16'h4000);
    check("R3 cascade of two halvings", lastOut, 4096);

    // sweep all orders with mixed coefficients
    for (int k = 0; k < 8; k++)
      for (int j = 0; j < 7; j++)
        cfgWrite(k, j, int'($urandom_range(0, 4095)) - 2048);
    for (int s = 0; s < 8; s++) begin
      setSel(s);
      for (int t = 0; t < 12; t++)
        sendWait(int'($urandom_range(0, 65535)) - 32768);
    end

    repeat (5) @(posedge clk);
    finishRun();
  end
endmodule